// File: doc/BRIEF.md
# Bank Select Register Unit

This unit keeps the two bank selectors of a small 4-bit controller core. One is a 4-bit memory bank selector that supplies the top nibble of a 12-bit data memory address. The other is a 2-bit register bank selector that picks one of four general register banks. Decoded select commands from the instruction decoder update either selector from a shared operand field. The memory bank selector only takes the values 0, 1, 2, 3 and 15. Any other operand is refused and reported with a one-cycle flag.

Both selectors can be saved to a stack and restored from it as a single byte. The byte layout is: memory bank in bits 7..4, constant zeros in bits 3..2, register bank in bits 1..0.

- **Save (push) path.** A push request captures the byte into an outgoing valid/ready holding stage. The stage keeps `push_valid` high and `push_byte` stable until the consumer raises `push_ready`. A new push request made while a capture is still waiting, and not being taken in that cycle, is dropped.
- **Restore (pop) path.** The pop input is a valid/ready stream whose ready is always high, so the stack side never sees back-pressure.

Two enable flags gate the outputs. While the memory enable is low the address nibble reads 0. While the register enable is low, register bank 0 is used.

All state changes on the rising clock edge. Reset is synchronous and active high.

Top module: `bank_sel_unit`

## Requirements
- R1: While `rst` is high at a rising edge, both selectors become 0, `push_valid` becomes 0 and `bad_bank` becomes 0.
- R2: A `sel_rb` strobe without `pop_valid` loads `sel_arg[1:0]` into the register bank selector at that edge.
- R3: A `sel_mb` strobe without `pop_valid` whose `sel_arg` is 0, 1, 2, 3 or 15 loads it into the memory bank selector at that edge, so the selector never holds any other value.
- R4: A `sel_mb` strobe without `pop_valid` whose `sel_arg` is 4 to 14 leaves the memory bank selector unchanged and raises `bad_bank` for exactly the following cycle. `bad_bank` is never high otherwise.
- R5: `reg_bank` is 0 while `rb_en` is 0 and equals the register bank selector while `rb_en` is 1.
- R6: `addr_hi` is 0 while `mb_en` is 0 and equals the memory bank selector while `mb_en` is 1.
- R7: A `push_req` accepted at an edge makes `push_valid` 1 after that edge, with `push_byte` = {memory bank (7..4), 2'b00 (3..2), register bank (1..0)} taken from the selectors before that edge. `push_valid` and `push_byte` hold until an edge where `push_ready` is 1, after which `push_valid` is 0 unless a new request is accepted in that same edge.
- R8: A pop (`pop_valid` at an edge) loads `pop_byte[1:0]` into the register bank selector and ignores `pop_byte[3:2]`. It loads `pop_byte[7:4]` into the memory bank selector only if that value is 0 to 3 or 15; otherwise the memory bank selector keeps its value, and no `bad_bank` pulse follows.
- R9: When `pop_valid` coincides with `sel_mb` or `sel_rb`, the pop alone takes effect, and `bad_bank` stays 0 in the next cycle.
- R10: `pop_ready` is 1 in every cycle.
- R11: A `push_req` arriving while `push_valid` is 1 and `push_ready` is 0 is ignored: `push_byte` keeps its earlier value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| sel_mb | input | 1 | Memory bank select command strobe |
| sel_rb | input | 1 | Register bank select command strobe |
| sel_arg | input | 4 | Operand of the select commands |
| mb_en | input | 1 | Memory bank enable flag |
| rb_en | input | 1 | Register bank enable flag |
| push_req | input | 1 | Request to save the selectors |
| push_ready | input | 1 | Save stream consumer ready |
| push_valid | output | 1 | Save stream byte valid |
| push_byte | output | 8 | Saved selector byte |
| pop_valid | input | 1 | Restore stream byte valid |
| pop_byte | input | 8 | Restored selector byte |
| pop_ready | output | 1 | Restore stream ready, always 1 |
| addr_hi | output | 4 | Upper nibble of the data memory address |
| reg_bank | output | 2 | Effective register bank |
| bad_bank | output | 1 | One-cycle flag for a refused memory bank operand |

## Verification
The hardest situations to reach from the ports are the ones where several things happen in the same edge. Examples are a pop that lands together with a select command carrying a refused operand, and a pop whose memory nibble is out of range while its register field is valid. The selectors can only be read through `addr_hi`, `reg_bank` and the save stream. So the bench first drives the unit to a known, non-zero state. It then applies the colliding stimulus and reads the result back both through the enabled outputs and through a fresh push. This shows that the zero bits stay clear and that a refused nibble left the previous bank in place. The save-stream stall is reached by holding `push_ready` low across a selector change and a second push request.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
  localparam int MB_W   = 4;
  localparam int RB_W   = 2;
  localparam int GAP_W  = 2;
  localparam int BYTE_W = MB_W + GAP_W + RB_W;
  localparam int LOW_LIMIT = 4;

  typedef logic [MB_W-1:0]   mb_t;
  typedef logic [RB_W-1:0]   rb_t;
  typedef logic [BYTE_W-1:0] sbyte_t;

  function automatic logic mb_legal(input mb_t v);
    return (v < mb_t'(LOW_LIMIT)) || (v == '1);
  endfunction

  function automatic sbyte_t pack_sel(input mb_t m, input rb_t r);
    return {m, {GAP_W{1'b0}}, r};
  endfunction

  function automatic mb_t unpack_mb(input sbyte_t b);
    return b[BYTE_W-1 -: MB_W];
  endfunction

  function automatic rb_t unpack_rb(input sbyte_t b);
    return b[RB_W-1:0];
  endfunction
endpackage

// File: rtl/bsu_mb_reg.sv
module bsu_mb_reg
  import bsu_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cmd,
  input  mb_t  cmd_val,
  input  logic load,
  input  mb_t  load_val,
  output mb_t  sel_q,
  output logic refused_q
);
  logic cmd_ok;
  assign cmd_ok = mb_legal(cmd_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q     <= '0;
      refused_q <= 1'b0;
    end else begin
      refused_q <= cmd && !load && !cmd_ok;
      if (load) begin
        if (mb_legal(load_val)) sel_q <= load_val;
      end else if (cmd && cmd_ok) begin
        sel_q <= cmd_val;
      end
    end
  end
endmodule

// File: rtl/bsu_rb_reg.sv
module bsu_rb_reg
  import bsu_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cmd,
  input  rb_t  cmd_val,
  input  logic load,
  input  rb_t  load_val,
  output rb_t  sel_q
);
  always_ff @(posedge clk) begin
    if (rst)       sel_q <= '0;
    else if (load) sel_q <= load_val;
    else if (cmd)  sel_q <= cmd_val;
  end
endmodule

// File: rtl/bsu_push_stage.sv
module bsu_push_stage
  import bsu_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   req,
  input  sbyte_t snap,
  input  logic   ready,
  output logic   valid,
  output sbyte_t data
);
  logic take;
  assign take = req && (!valid || ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (take) begin
      valid <= 1'b1;
      data  <= snap;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bank_sel_unit.sv
module bank_sel_unit
  import bsu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_mb,
  input  logic              sel_rb,
  input  logic [MB_W-1:0]   sel_arg,
  input  logic              mb_en,
  input  logic              rb_en,
  input  logic              push_req,
  input  logic              push_ready,
  output logic              push_valid,
  output logic [BYTE_W-1:0] push_byte,
  input  logic              pop_valid,
  input  logic [BYTE_W-1:0] pop_byte,
  output logic              pop_ready,
  output logic [MB_W-1:0]   addr_hi,
  output logic [RB_W-1:0]   reg_bank,
  output logic              bad_bank
);
  mb_t mb_q;
  rb_t rb_q;

  assign pop_ready = 1'b1;

  bsu_mb_reg i_mb (
    .clk(clk), .rst(rst),
    .cmd(sel_mb), .cmd_val(sel_arg),
    .load(pop_valid), .load_val(unpack_mb(pop_byte)),
    .sel_q(mb_q), .refused_q(bad_bank)
  );

  bsu_rb_reg i_rb (
    .clk(clk), .rst(rst),
    .cmd(sel_rb), .cmd_val(sel_arg[RB_W-1:0]),
    .load(pop_valid), .load_val(unpack_rb(pop_byte)),
    .sel_q(rb_q)
  );

  bsu_push_stage i_push (
    .clk(clk), .rst(rst),
    .req(push_req), .snap(pack_sel(mb_q, rb_q)),
    .ready(push_ready), .valid(push_valid), .data(push_byte)
  );

  assign addr_hi  = mb_en ? mb_q : '0;
  assign reg_bank = rb_en ? rb_q : '0;
endmodule

// File: rtl/bsu_checker.sv
module bsu_checker
  import bsu_pkg::*;
(
  input logic   clk,
  input logic   rst,
  input logic   sel_mb,
  input logic   sel_rb,
  input mb_t    sel_arg,
  input logic   rb_en,
  input logic   push_ready,
  input logic   push_valid,
  input sbyte_t push_byte,
  input logic   pop_valid,
  input sbyte_t pop_byte,
  input logic   pop_ready,
  input logic [RB_W-1:0] reg_bank,
  input logic   bad_bank,
  input mb_t    mb_q,
  input rb_t    rb_q
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (mb_q == '0 && rb_q == '0 && !push_valid && !bad_bank));

  p_rb_load_r2: assert property (@(posedge clk) disable iff (rst)
    (sel_rb && !pop_valid) |=> rb_q == $past(sel_arg[RB_W-1:0]));

  p_mb_range_r3: assert property (@(posedge clk) disable iff (rst)
    (mb_q < mb_t'(LOW_LIMIT)) || (mb_q == '1));

  p_refuse_r4: assert property (@(posedge clk) disable iff (rst)
    (sel_mb && !pop_valid && sel_arg >= mb_t'(LOW_LIMIT) && sel_arg != '1)
      |=> (bad_bank && $stable(mb_q)));

  p_flag_cause_r4: assert property (@(posedge clk) disable iff (rst)
    bad_bank |-> $past(sel_mb && !pop_valid));

  p_rb_off_r5: assert property (@(posedge clk) disable iff (rst)
    !rb_en |-> reg_bank == '0);

  p_push_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (push_valid && !push_ready) |=> (push_valid && $stable(push_byte)));

  p_pop_wins_r9: assert property (@(posedge clk) disable iff (rst)
    pop_valid |=> (!bad_bank && rb_q == $past(pop_byte[RB_W-1:0])));

  p_ready_r10: assert property (@(posedge clk) disable iff (rst)
    pop_ready);
endmodule

bind bank_sel_unit bsu_checker i_bsu_checker (
  .clk(clk), .rst(rst), .sel_mb(sel_mb), .sel_rb(sel_rb), .sel_arg(sel_arg),
  .rb_en(rb_en), .push_ready(push_ready), .push_valid(push_valid),
  .push_byte(push_byte), .pop_valid(pop_valid), .pop_byte(pop_byte),
  .pop_ready(pop_ready), .reg_bank(reg_bank), .bad_bank(bad_bank),
  .mb_q(mb_q), .rb_q(rb_q)
);

// File: tb/test_bank_sel_unit.sv
module test_bank_sel_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst, sel_mb, sel_rb, mb_en, rb_en;
  logic       push_req, push_ready, push_valid, pop_valid, pop_ready, bad_bank;
  logic [3:0] sel_arg, addr_hi;
  logic [7:0] push_byte, pop_byte;
  logic [1:0] reg_bank;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_sel_unit i_bank_sel_unit (
    .clk(clk), .rst(rst), .sel_mb(sel_mb), .sel_rb(sel_rb), .sel_arg(sel_arg),
    .mb_en(mb_en), .rb_en(rb_en), .push_req(push_req), .push_ready(push_ready),
    .push_valid(push_valid), .push_byte(push_byte), .pop_valid(pop_valid),
    .pop_byte(pop_byte), .pop_ready(pop_ready), .addr_hi(addr_hi),
    .reg_bank(reg_bank), .bad_bank(bad_bank)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    sel_mb = 0; sel_rb = 0; push_req = 0; pop_valid = 0;
  endtask

  // Inputs are driven just after a falling edge; one step crosses one rising edge.
  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic set_mb(input logic [3:0] v);
    sel_mb = 1; sel_arg = v; step();
  endtask

  task automatic set_rb(input logic [1:0] v);
    sel_rb = 1; sel_arg = {2'b00, v}; step();
  endtask

  task automatic read_back(input string req, input logic [7:0] exp);
    push_ready = 1; push_req = 1; step();
    check(req, {7'd0, push_valid}, 8'd1);
    check(req, push_byte, exp);
    step();
  endtask

  task automatic t_reset();
    rst = 1; mb_en = 1; rb_en = 1; push_ready = 0; sel_arg = 0; pop_byte = 0;
    idle();
    step(); step();
    rst = 0;
    check("R1 addr_hi", {4'd0, addr_hi}, 8'h00);
    check("R1 reg_bank", {6'd0, reg_bank}, 8'h00);
    check("R1 push_valid", {7'd0, push_valid}, 8'h00);
    check("R1 bad_bank", {7'd0, bad_bank}, 8'h00);
    check("R10 pop_ready", {7'd0, pop_ready}, 8'h01);
  endtask

  task automatic t_rb_select();
    for (int n = 0; n < 4; n++) begin
      set_rb(2'(n));
      check("R2 reg_bank", {6'd0, reg_bank}, 8'(n));
    end
    rb_en = 0; #1;
    check("R5 rb_en low", {6'd0, reg_bank}, 8'h00);
    rb_en = 1; #1;
    check("R5 rb_en high", {6'd0, reg_bank}, 8'h03);
  endtask

  task automatic t_mb_select();
    logic [3:0] legal [5] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd15};
    foreach (legal[i]) begin
      set_mb(legal[i]);
      check("R3 addr_hi", {4'd0, addr_hi}, {4'd0, legal[i]});
      check("R4 no flag", {7'd0, bad_bank}, 8'h00);
    end
    set_mb(4'd2);
    for (int v = 4; v < 15; v++) begin
      set_mb(4'(v));
      check("R4 kept", {4'd0, addr_hi}, 8'h02);
      check("R4 flag", {7'd0, bad_bank}, 8'h01);
      step();
      check("R4 flag one cycle", {7'd0, bad_bank}, 8'h00);
    end
  endtask

  task automatic t_enable();
    set_mb(4'd15);
    mb_en = 0; #1;
    check("R6 mb_en low", {4'd0, addr_hi}, 8'h00);
    mb_en = 1; #1;
    check("R6 mb_en high", {4'd0, addr_hi}, 8'h0F);
  endtask

  task automatic t_push();
    set_mb(4'd3); set_rb(2'd2);
    push_ready = 0; push_req = 1; step();
    check("R7 valid", {7'd0, push_valid}, 8'h01);
    check("R7 byte", push_byte, 8'h32);
    set_mb(4'd15);
    push_req = 1; step();
    check("R11 ignored", push_byte, 8'h32);
    check("R7 still valid", {7'd0, push_valid}, 8'h01);
    push_ready = 1; step();
    check("R7 drained", {7'd0, push_valid}, 8'h00);
    read_back("R7 new byte", 8'hF2);
  endtask

  task automatic t_pop();
    pop_valid = 1; pop_byte = 8'h1D; step();
    check("R8 addr_hi", {4'd0, addr_hi}, 8'h01);
    check("R8 reg_bank", {6'd0, reg_bank}, 8'h01);
    read_back("R8 zero bits", 8'h11);
    pop_valid = 1; pop_byte = 8'h73; step();
    check("R8 bad nibble kept", {4'd0, addr_hi}, 8'h01);
    check("R8 rb loaded", {6'd0, reg_bank}, 8'h03);
    check("R8 no flag", {7'd0, bad_bank}, 8'h00);
  endtask

  task automatic t_priority();
    pop_valid = 1; pop_byte = 8'h20;
    sel_mb = 1; sel_rb = 1; sel_arg = 4'd5; step();
    check("R9 mb from pop", {4'd0, addr_hi}, 8'h02);
    check("R9 rb from pop", {6'd0, reg_bank}, 8'h00);
    check("R9 no flag", {7'd0, bad_bank}, 8'h00);
    pop_valid = 1; pop_byte = 8'hF1;
    sel_mb = 1; sel_arg = 4'd3; step();
    check("R9 legal cmd loses", {4'd0, addr_hi}, 8'h0F);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_rb_select();
    t_mb_select();
    t_enable();
    t_push();
    t_pop();
    t_priority();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule